// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the trigger sequencer of an on-chip debug unit. It walks through three intermediate states and a Final state in response to three comparator match channels. Each comparator is modelled here as a match input plus an enable bit. Each intermediate state owns a 4-bit select register. The code in that register decides which match moves the sequencer to which next state.

When matches arrive together, a match that leads to Final always wins. Failing that, the lowest numbered channel wins. Reaching Final raises a one-cycle trigger pulse and disarms the sequencer. It then stays in Final until it is armed again.

The three select registers share one bus address. A 2-bit bank field chooses which of them is seen there. While the sequencer is armed, writes to the select registers are refused, so a trigger program cannot change in the middle of a run.

Top module: `dbg_seq_top`

## Requirements
- R1: After a synchronous reset, `seq_state` is 2'b00 (Final), `armed` is 0, `final_pulse` is 0 and all three select registers read 0.
- R2: The select registers sit at bus address 0x27. Bank 2'b00 maps to the State1 register, 2'b01 to State2 and 2'b10 to State3. Bank 2'b11, or any other address, reads 0 and ignores writes. Bits 7:4 of a select register always read 0, and only write bits 3:0 are stored.
- R3: While `armed` is 1, writes to any select register have no effect.
- R4: State codes are 2'b01 State1, 2'b10 State2, 2'b11 State3 and 2'b00 Final. An `arm` pulse without `disarm` gives State1 with `armed`=1 after the next edge, and it overrides any match in that cycle. `disarm` clears `armed`, keeps the state and wins over `arm`. While disarmed, matches change nothing.
- R5: A match counts only if the same channel's bit of `match_en` is set. A transition shows one edge after the match is sampled, and at most one transition happens per edge.
- R6: State1 codes. 0000: Match0 to State2. 0001: Match1 to State2. 0010: Match2 to State2. 0011: Match0 to Final. 0100: Match1 to Final. 0101: Match2 to Final. 0110: Match0 to State3. 0111: Match1 to State3. 1000: Match2 to State3. 1001: Match0 to State2 and Match1 to Final. 1010: Match1 to State3 and Match2 to Final. 1011: Match0 to State3 and Match2 to State2.
- R7: State2 codes. 0000: Match0 to State1. 0001: Match1 to State1. 0010: Match2 to State1. 0011: Match1 to State3. 0100: Match2 to State3. 0101: Match2 to Final. 0110: Match0 to Final and Match2 to State1. 0111: Match0 or Match1 to Final. 1100: Match0 or Match1 to Final and Match2 to State3. 1111: Match0 or Match1 to Final and Match2 to State1.
- R8: State3 codes. 0000: Match0 to State1. 0001: Match1 to State1. 0010: Match2 to State1. 0011: Match0 to Final. 0100: Match1 to Final. 0101: Match2 to Final. 0110: Match0 to State2. 0111: Match1 to State2. 1000: Match2 to State2. 1001: Match0 to State1 and Match2 to Final. 1010: Match1 to State2 and Match0 to Final.
- R9: Codes not listed in R6 to R8 are reserved and cause no transition. A match that the selected code does not name has no effect.
- R10: Among simultaneous counted matches, one that leads to Final wins. Otherwise the lowest channel number wins.
- R11: Entering Final sets `final_pulse` for exactly one cycle and clears `armed` on the same edge. The state then holds Final until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm request: enter State1 |
| disarm | input | 1 | Disarm request |
| match_hit | input | 3 | Comparator match channels 0..2 |
| match_en | input | 3 | Comparator channel enables |
| bank_sel | input | 2 | Selects which select register shows at the shared address |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| seq_state | output | 2 | Current sequencer state |
| armed | output | 1 | Sequencer armed |
| final_pulse | output | 1 | One-cycle pulse on entry to Final |

## Verification
Two pairs of functions can fall in the same cycle, and both are provoked on purpose.

The first pair is two transition routes. The bench drives several enabled matches in one cycle under codes whose named channels lead to different targets. Some of these codes also name a Final route on a higher channel. The state seen one edge later must show the Final route winning, and otherwise the lowest channel.

The second pair is arming and disarming against matches and register writes. The bench raises `arm` together with a Final-leading match, raises `arm` together with `disarm`, and writes a select register while armed. The state, the `armed` flag and the register read-back must show that arm overrides matches, that disarm overrides arm, and that the write was refused.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    localparam int NCH    = 3;   // comparator match channels
    localparam int NSTG   = 3;   // intermediate states with a select register
    localparam int SC_W   = 4;   // select code width
    localparam int BANK_W = 2;   // bank-select width

    typedef enum logic [1:0] {
        ST_FIN = 2'b00,
        ST_S1  = 2'b01,
        ST_S2  = 2'b10,
        ST_S3  = 2'b11
    } seq_st_e;

    typedef enum logic [2:0] {
        T_NONE = 3'd0,
        T_S1   = 3'd1,
        T_S2   = 3'd2,
        T_S3   = 3'd3,
        T_FIN  = 3'd4
    } tgt_e;

    typedef tgt_e [NCH-1:0] route_t;

    typedef logic [SC_W-1:0] code_t;

    function automatic route_t mk_route(tgt_e t0, tgt_e t1, tgt_e t2);
        route_t r;
        r[0] = t0;
        r[1] = t1;
        r[2] = t2;
        return r;
    endfunction

    localparam route_t NO_ROUTE = {T_NONE, T_NONE, T_NONE};

    // State1 routing table
    function automatic route_t s1_route(code_t c);
        case (c)
            4'h0:    return mk_route(T_S2,   T_NONE, T_NONE);
            4'h1:    return mk_route(T_NONE, T_S2,   T_NONE);
            4'h2:    return mk_route(T_NONE, T_NONE, T_S2);
            4'h3:    return mk_route(T_FIN,  T_NONE, T_NONE);
            4'h4:    return mk_route(T_NONE, T_FIN,  T_NONE);
            4'h5:    return mk_route(T_NONE, T_NONE, T_FIN);
            4'h6:    return mk_route(T_S3,   T_NONE, T_NONE);
            4'h7:    return mk_route(T_NONE, T_S3,   T_NONE);
            4'h8:    return mk_route(T_NONE, T_NONE, T_S3);
            4'h9:    return mk_route(T_S2,   T_FIN,  T_NONE);
            4'hA:    return mk_route(T_NONE, T_S3,   T_FIN);
            4'hB:    return mk_route(T_S3,   T_NONE, T_S2);
            default: return NO_ROUTE;
        endcase
    endfunction

    // State2 routing table
    function automatic route_t s2_route(code_t c);
        case (c)
            4'h0:    return mk_route(T_S1,   T_NONE, T_NONE);
            4'h1:    return mk_route(T_NONE, T_S1,   T_NONE);
            4'h2:    return mk_route(T_NONE, T_NONE, T_S1);
            4'h3:    return mk_route(T_NONE, T_S3,   T_NONE);
            4'h4:    return mk_route(T_NONE, T_NONE, T_S3);
            4'h5:    return mk_route(T_NONE, T_NONE, T_FIN);
            4'h6:    return mk_route(T_FIN,  T_NONE, T_S1);
            4'h7:    return mk_route(T_FIN,  T_FIN,  T_NONE);
            4'hC:    return mk_route(T_FIN,  T_FIN,  T_S3);
            4'hF:    return mk_route(T_FIN,  T_FIN,  T_S1);
            default: return NO_ROUTE;
        endcase
    endfunction

    // State3 routing table
    function automatic route_t s3_route(code_t c);
        case (c)
            4'h0:    return mk_route(T_S1,   T_NONE, T_NONE);
            4'h1:    return mk_route(T_NONE, T_S1,   T_NONE);
            4'h2:    return mk_route(T_NONE, T_NONE, T_S1);
            4'h3:    return mk_route(T_FIN,  T_NONE, T_NONE);
            4'h4:    return mk_route(T_NONE, T_FIN,  T_NONE);
            4'h5:    return mk_route(T_NONE, T_NONE, T_FIN);
            4'h6:    return mk_route(T_S2,   T_NONE, T_NONE);
            4'h7:    return mk_route(T_NONE, T_S2,   T_NONE);
            4'h8:    return mk_route(T_NONE, T_NONE, T_S2);
            4'h9:    return mk_route(T_S1,   T_NONE, T_FIN);
            4'hA:    return mk_route(T_FIN,  T_S2,   T_NONE);
            default: return NO_ROUTE;
        endcase
    endfunction

    function automatic seq_st_e tgt_to_st(tgt_e t);
        case (t)
            T_S1:    return ST_S1;
            T_S2:    return ST_S2;
            T_S3:    return ST_S3;
            default: return ST_FIN;
        endcase
    endfunction

endpackage

// File: rtl/dbg_seq_regs.sv
module dbg_seq_regs
    import dbg_seq_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h27
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          lock,
    input  logic [BANK_W-1:0]             bank_sel,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [SC_W-1:0]               wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NSTG-1:0][SC_W-1:0]     sc_all
);

    localparam int PAD_W = DATA_W - SC_W;

    logic addr_hit;
    logic bank_ok;
    logic wr_hit;

    assign addr_hit = (addr == SEL_ADDR);
    assign bank_ok  = (32'(bank_sel) < NSTG);
    assign wr_hit   = wr_en && addr_hit && bank_ok && !lock;

    for (genvar g = 0; g < NSTG; g++) begin : g_sc
        always_ff @(posedge clk) begin
            if (rst) begin
                sc_all[g] <= '0;
            end else if (wr_hit && (bank_sel == BANK_W'(g))) begin
                sc_all[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_hit && bank_ok) begin
            rdata = {{PAD_W{1'b0}}, sc_all[bank_sel]};
        end
    end

endmodule

// File: rtl/dbg_seq_route.sv
module dbg_seq_route
    import dbg_seq_pkg::*;
(
    input  seq_st_e                      cur_st,
    input  logic [NSTG-1:0][SC_W-1:0]    sc_all,
    input  logic [NCH-1:0]               match_hit,
    input  logic [NCH-1:0]               match_en,
    output logic                         nxt_ok,
    output seq_st_e                      nxt_st
);

    route_t sel_route;
    route_t eff;
    tgt_e   win;

    always_comb begin
        case (cur_st)
            ST_S1:   sel_route = s1_route(sc_all[0]);
            ST_S2:   sel_route = s2_route(sc_all[1]);
            ST_S3:   sel_route = s3_route(sc_all[2]);
            default: sel_route = NO_ROUTE;
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_gate
        assign eff[g] = (match_hit[g] && match_en[g]) ? sel_route[g] : T_NONE;
    end

    // Final wins; otherwise the lowest channel (scanned last) wins.
    always_comb begin
        win = T_NONE;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (eff[i] != T_NONE) win = eff[i];
        end
        for (int i = 0; i < NCH; i++) begin
            if (eff[i] == T_FIN) win = T_FIN;
        end
    end

    assign nxt_ok = (win != T_NONE);
    assign nxt_st = tgt_to_st(win);

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     arm,
    input  logic     disarm,
    input  logic     nxt_ok,
    input  seq_st_e  nxt_st,
    output seq_st_e  cur_st,
    output logic     armed,
    output logic     fin_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_st    <= ST_FIN;
            armed     <= 1'b0;
            fin_pulse <= 1'b0;
        end else begin
            fin_pulse <= 1'b0;
            if (disarm) begin
                armed <= 1'b0;
            end else if (arm) begin
                cur_st <= ST_S1;
                armed  <= 1'b1;
            end else if (armed && nxt_ok) begin
                cur_st <= nxt_st;
                if (nxt_st == ST_FIN) begin
                    armed     <= 1'b0;
                    fin_pulse <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
    import dbg_seq_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h27
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arm,
    input  logic                 disarm,
    input  logic [NCH-1:0]       match_hit,
    input  logic [NCH-1:0]       match_en,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [1:0]           seq_state,
    output logic                 armed,
    output logic                 final_pulse
);

    logic [NSTG-1:0][SC_W-1:0] sc_all;
    seq_st_e                   cur_st;
    seq_st_e                   nxt_st;
    logic                      nxt_ok;
    logic                      unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SC_W];

    dbg_seq_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SEL_ADDR (SEL_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .lock     (armed),
        .bank_sel (bank_sel),
        .wr_en    (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata[SC_W-1:0]),
        .rdata    (bus_rdata),
        .sc_all   (sc_all)
    );

    dbg_seq_route route_i (
        .cur_st    (cur_st),
        .sc_all    (sc_all),
        .match_hit (match_hit),
        .match_en  (match_en),
        .nxt_ok    (nxt_ok),
        .nxt_st    (nxt_st)
    );

    dbg_seq_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .disarm    (disarm),
        .nxt_ok    (nxt_ok),
        .nxt_st    (nxt_st),
        .cur_st    (cur_st),
        .armed     (armed),
        .fin_pulse (final_pulse)
    );

    assign seq_state = cur_st;

endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SC_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              arm,
    input logic              disarm,
    input logic [1:0]        bank_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [1:0]        seq_state,
    input logic              armed,
    input logic              final_pulse
);

    a_r11_pulse_single: assert property (@(posedge clk) disable iff (rst)
        final_pulse |=> !final_pulse);

    a_r11_pulse_in_final: assert property (@(posedge clk) disable iff (rst)
        final_pulse |-> (seq_state == 2'b00 && !armed));

    a_r4_arm_enters_s1: assert property (@(posedge clk) disable iff (rst)
        (arm && !disarm) |=> (armed && seq_state == 2'b01));

    a_r4_disarm_wins: assert property (@(posedge clk) disable iff (rst)
        disarm |=> !armed);

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!armed && !arm) |=> $stable(seq_state));

    a_r3_locked_writes: assert property (@(posedge clk) disable iff (rst)
        armed |=> (bus_addr != $past(bus_addr) || bank_sel != $past(bank_sel)
                   || bus_rdata == $past(bus_rdata)));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:SC_W] == '0);

endmodule

bind dbg_seq_top dbg_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SC_W   (dbg_seq_pkg::SC_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .arm         (arm),
    .disarm      (disarm),
    .bank_sel    (bank_sel),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .seq_state   (seq_state),
    .armed       (armed),
    .final_pulse (final_pulse)
);

// File: tb/dbg_seq_top_tb_top.sv
`timescale 1ns/1ps
module dbg_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       arm, disarm;
    logic [2:0] match_hit, match_en;
    logic [1:0] bank_sel;
    logic       bus_we;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0] seq_state;
    logic       armed, final_pulse;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dbg_seq_top dut_i (
        .clk (clk), .rst (rst), .arm (arm), .disarm (disarm),
        .match_hit (match_hit), .match_en (match_en), .bank_sel (bank_sel),
        .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .seq_state (seq_state), .armed (armed),
        .final_pulse (final_pulse)
    );

    localparam logic [1:0] SF = 2'b00, S1 = 2'b01, S2 = 2'b10, S3 = 2'b11;

    // kind: 0 table entry, 1 reserved/unnamed, 2 priority, 3 enable gating
    typedef struct packed {
        logic [1:0] st;
        logic [3:0] code;
        logic [2:0] m;
        logic [2:0] en;
        logic [1:0] exp;
        logic [1:0] kind;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{S1, 4'h0, 3'b001, 3'b111, S2, 2'd0},
        '{S1, 4'h0, 3'b010, 3'b111, S1, 2'd1},
        '{S1, 4'h5, 3'b100, 3'b111, SF, 2'd0},
        '{S1, 4'h9, 3'b011, 3'b111, SF, 2'd2},
        '{S1, 4'hC, 3'b111, 3'b111, S1, 2'd1},
        '{S1, 4'hB, 3'b101, 3'b111, S3, 2'd2},
        '{S1, 4'h7, 3'b010, 3'b111, S3, 2'd0},
        '{S2, 4'h5, 3'b100, 3'b111, SF, 2'd0},
        '{S2, 4'h6, 3'b101, 3'b111, SF, 2'd2},
        '{S2, 4'h6, 3'b100, 3'b111, S1, 2'd0},
        '{S2, 4'h7, 3'b010, 3'b111, SF, 2'd0},
        '{S2, 4'hC, 3'b100, 3'b111, S3, 2'd0},
        '{S2, 4'hF, 3'b100, 3'b111, S1, 2'd0},
        '{S2, 4'hA, 3'b111, 3'b111, S2, 2'd1},
        '{S2, 4'hC, 3'b010, 3'b101, S2, 2'd3},
        '{S2, 4'hC, 3'b110, 3'b101, S3, 2'd3},
        '{S3, 4'h0, 3'b001, 3'b111, S1, 2'd0},
        '{S3, 4'h8, 3'b100, 3'b111, S2, 2'd0},
        '{S3, 4'hA, 3'b011, 3'b111, SF, 2'd2},
        '{S3, 4'h3, 3'b110, 3'b111, S3, 2'd1}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] bank, input logic [7:0] addr,
                      input logic [7:0] data);
        bank_sel = bank; bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] bank, output logic [7:0] data);
        bank_sel = bank; bus_addr = 8'h27;
        #1;
        data = bus_rdata;
    endtask

    task automatic do_arm();    arm = 1'b1;    step(); arm = 1'b0;    endtask
    task automatic do_disarm(); disarm = 1'b1; step(); disarm = 1'b0; endtask

    task automatic run_vec(input vec_t v);
        string tag;
        do_disarm();
        if (v.st == S1) wr(2'd0, 8'h27, {4'h0, v.code});
        else if (v.st == S2) wr(2'd0, 8'h27, 8'h00);
        else wr(2'd0, 8'h27, 8'h06);
        if (v.st != S1) wr(v.st - 2'd1, 8'h27, {4'h0, v.code});
        do_arm();
        if (v.st != S1) begin
            match_hit = 3'b001; match_en = 3'b111;
            step();
            match_hit = 3'b000;
        end
        check("R4", "start state", seq_state, v.st);
        match_hit = v.m; match_en = v.en;
        step();
        match_hit = 3'b000; match_en = 3'b111;
        case (v.kind)
            2'd1: tag = "R9";
            2'd2: tag = "R10";
            2'd3: tag = "R5";
            default: tag = (v.st == S1) ? "R6" : (v.st == S2) ? "R7" : "R8";
        endcase
        check(tag, $sformatf("st%0d code %h next", v.st, v.code), seq_state, v.exp);
        check(tag, "pulse", final_pulse, v.exp == SF);
        check(tag, "armed", armed, v.exp != SF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; arm = 0; disarm = 0; match_hit = 0; match_en = 3'b111;
        bank_sel = 0; bus_we = 0; bus_addr = 8'h27; bus_wdata = 0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1", "state", seq_state, SF);
        check("R1", "armed", armed, 0);
        check("R1", "pulse", final_pulse, 0);
        for (int b = 0; b < 3; b++) begin
            rd(2'(b), r);
            check("R1", "select reg", r, 0);
        end

        // R2 banking and field width
        wr(2'd0, 8'h27, 8'hA5);
        rd(2'd0, r); check("R2", "upper bits dropped", r, 8'h05);
        wr(2'd3, 8'h27, 8'hFF);
        rd(2'd3, r); check("R2", "bank 11 reads 0", r, 0);
        rd(2'd1, r); check("R2", "bank 01 untouched", r, 0);
        rd(2'd2, r); check("R2", "bank 10 untouched", r, 0);
        wr(2'd1, 8'h26, 8'h0F);
        rd(2'd1, r); check("R2", "other address write ignored", r, 0);
        bus_addr = 8'h26; #1;
        check("R2", "other address reads 0", bus_rdata, 0);
        wr(2'd2, 8'h27, 8'h09);
        rd(2'd2, r); check("R2", "bank 10 maps State3", r, 8'h09);

        // R3 locked while armed
        do_arm();
        wr(2'd1, 8'h27, 8'h07);
        rd(2'd1, r); check("R3", "write while armed", r, 0);

        // Table walk
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R11 pulse, disarm, hold
        do_disarm();
        wr(2'd0, 8'h27, 8'h03);
        do_arm();
        match_hit = 3'b001; step(); match_hit = 0;
        check("R11", "enter final", seq_state, SF);
        check("R11", "pulse high", final_pulse, 1);
        check("R11", "disarmed", armed, 0);
        step();
        check("R11", "pulse one cycle", final_pulse, 0);
        match_hit = 3'b001; step(); match_hit = 0;
        check("R11", "holds final", seq_state, SF);
        check("R11", "no second pulse", final_pulse, 0);

        // R4 arm with a Final-leading match in the same cycle
        arm = 1; match_hit = 3'b001; step(); arm = 0; match_hit = 0;
        check("R4", "arm beats match", seq_state, S1);
        check("R4", "armed", armed, 1);
        check("R4", "no pulse", final_pulse, 0);
        disarm = 1; match_hit = 3'b001; step(); disarm = 0; match_hit = 0;
        check("R4", "disarm clears", armed, 0);
        check("R4", "disarm holds state", seq_state, S1);
        match_hit = 3'b001; step(); match_hit = 0;
        check("R4", "disarmed ignores match", seq_state, S1);
        arm = 1; disarm = 1; step(); arm = 0; disarm = 0;
        check("R4", "disarm beats arm", armed, 0);

        // R5 one transition per edge
        wr(2'd0, 8'h27, 8'h00);
        wr(2'd1, 8'h27, 8'h07);
        do_arm();
        match_hit = 3'b001; step();
        check("R5", "single hop", seq_state, S2);
        step(); match_hit = 0;
        check("R5", "second hop", seq_state, SF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule